// File: doc/BRIEF.md
# Two-Loop PI Duty Calculator for a Full-Bridge Converter

This block turns one set of converter measurements into two bridge-phase duty cycles. A sample strobe captures four values: the measured output voltage, its setpoint, the input line voltage and the averaged (DC) transformer primary current. An outer PI loop acts on the voltage error. Its output is divided by the line voltage as feed-forward, clipped to plus or minus one, and shifted into the range zero to one. The result is a common base duty.

An inner PI loop drives the DC primary current toward zero. Its output is bounded and then added to one phase and subtracted from the other. This cancels the DC bias that unequal switch conductance would build up in the transformer. Each phase duty is held at or below 95 % of the half period, which keeps a dead band between the phases. It is then quantized to an 8-bit code for a PWM stage.

A line-window check runs on every sample. If the line voltage is out of range, both duties are forced to zero, a trip flag is raised, and neither integrator moves. All arithmetic is signed fixed point, with duty in Q12 (4096 = 1.0) and gains carrying 8 fraction bits. The division is a restoring divider that takes one quotient bit per clock.

Top module: `bridge_duty_ctrl`

## Requirements
- R1: While reset is held and after it is released, before the first sample completes: `duty_a` = 0, `duty_b` = 0, `done` = 0 and `trip` = 1.
- R2: A strobe sampled while idle produces a single-cycle `done` pulse exactly 37 clock cycles later (AW+FRAC+1 with defaults). `duty_a`, `duty_b` and `trip` change only in the cycle in which `done` is high.
- R3: A strobe that arrives while a sample is still being computed is ignored. It produces no extra `done` and no change in the outputs, and none of the port values present at that strobe are used.
- R4: Voltage loop. err = v_set − v_meas. The integrator becomes clamp(integ + ((err·v_ki) >>> 8), v_int_lo, v_int_hi). The loop output is u = integ_new + ((err·v_kp) >>> 8), limited to ±(2^23 − 1). Every clamp replaces an out-of-range value with the violated bound.
- R5: Normalization. q = min(floor(|u|·4096 / v_line), 4096). x = q with the sign of u. The base duty is (x + 4096) >>> 1, in Q12.
- R6: Current loop. err = −i_dc, put through the same PI form with i_kp, i_ki, i_int_lo and i_int_hi. The correction is that output clamped to [−corr_lim, +corr_lim].
- R7: Phase A duty = base + correction and phase B duty = base − correction. Each is clamped to [0, 3891], which is 0.95 in Q12. The output code is (d·255) >> 12, so the largest code is 242.
- R8: A sample is a line fault when v_line ≤ 0, v_line < line_lo or v_line > line_hi. A value equal to line_lo or line_hi is in range. On a fault the result is both duties 0 and `trip` = 1, and neither integrator is updated.
- R9: `trip` returns to 0 with the result of the next sample that has no line fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe; all other inputs are captured in this cycle |
| v_meas | input | 16 | Measured output voltage, signed |
| v_set | input | 16 | Output voltage setpoint, signed |
| v_line | input | 16 | Input line voltage, signed |
| i_dc | input | 16 | Averaged primary current, signed |
| v_kp | input | 16 | Voltage-loop proportional gain, unsigned, 8 fraction bits |
| v_ki | input | 16 | Voltage-loop integral gain, unsigned, 8 fraction bits |
| i_kp | input | 16 | Current-loop proportional gain, unsigned, 8 fraction bits |
| i_ki | input | 16 | Current-loop integral gain, unsigned, 8 fraction bits |
| v_int_lo | input | 24 | Voltage integrator lower bound, signed |
| v_int_hi | input | 24 | Voltage integrator upper bound, signed |
| i_int_lo | input | 24 | Current integrator lower bound, signed |
| i_int_hi | input | 24 | Current integrator upper bound, signed |
| corr_lim | input | 16 | Magnitude bound of the phase correction, Q12, unsigned |
| line_lo | input | 16 | Lowest allowed line voltage, signed |
| line_hi | input | 16 | Highest allowed line voltage, signed |
| duty_a | output | 8 | Phase A duty code |
| duty_b | output | 8 | Phase B duty code |
| done | output | 1 | One-cycle pulse when new duties are present |
| trip | output | 1 | Line-fault shutdown flag |

## Verification
Both integrators advance in the strobe cycle. The duties, `trip` and `done` all appear 37 rising edges later. The bench drives the strobe on a falling edge and counts 37 rising edges. It samples every output on the falling edge that follows the 37th. At the falling edge before that, it confirms that `done` has stayed low and that the previous duties are still held. For the busy-strobe case, a second strobe is placed four edges into the computation. The bench then watches 40 further cycles for a stray pulse or an output change.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } bdc_state_e;

   localparam int BDC_PHASES = 2;

endpackage

// File: rtl/bdc_clamp.sv
module bdc_clamp #(
   parameter int IW = 16,
   parameter int OW = 16
) (
   input  logic signed [IW-1:0] v,
   input  logic signed [IW-1:0] lo,
   input  logic signed [IW-1:0] hi,
   output logic signed [OW-1:0] y
);

   if (OW > IW) begin : g_chk
      $error("bdc_clamp: OW must not exceed IW");
   end

   logic signed [IW-1:0] sel;

   always_comb begin
      if (v > hi)
         sel = hi;
      else if (v < lo)
         sel = lo;
      else
         sel = v;
      y = OW'(sel);
   end

endmodule

// File: rtl/bdc_pi.sv
module bdc_pi #(
   parameter int EW    = 17,
   parameter int GW    = 16,
   parameter int AW    = 24,
   parameter int GF    = 8,
   parameter bit USE_P = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd,
   input  logic signed [EW-1:0] err,
   input  logic        [GW-1:0] kp,
   input  logic        [GW-1:0] ki,
   input  logic signed [AW-1:0] lo,
   input  logic signed [AW-1:0] hi,
   output logic signed [AW-1:0] u
);

   localparam int PW = EW + GW + 1;
   localparam int SW = PW + 1;
   localparam logic signed [SW-1:0] U_HI = (SW'(1) <<< (AW - 1)) - SW'(1);
   localparam logic signed [SW-1:0] U_LO = -U_HI;

   if (SW <= AW) begin : g_chk
      $error("bdc_pi: product width must exceed accumulator width");
   end

   logic signed [AW-1:0] integ;
   logic signed [AW-1:0] integ_nx;
   logic signed [PW-1:0] i_prod;
   logic signed [SW-1:0] i_sum;
   logic signed [SW-1:0] lo_w;
   logic signed [SW-1:0] hi_w;
   logic signed [SW-1:0] p_term;
   logic signed [SW-1:0] u_raw;

   assign i_prod = err * $signed({1'b0, ki});
   assign i_sum  = {{(SW-AW){integ[AW-1]}}, integ} + SW'(i_prod >>> GF);
   assign lo_w   = {{(SW-AW){lo[AW-1]}}, lo};
   assign hi_w   = {{(SW-AW){hi[AW-1]}}, hi};

   bdc_clamp #(.IW(SW), .OW(AW)) u_int_lim (
      .v  (i_sum),
      .lo (lo_w),
      .hi (hi_w),
      .y  (integ_nx)
   );

   if (USE_P) begin : g_prop
      logic signed [PW-1:0] p_prod;
      assign p_prod = err * $signed({1'b0, kp});
      assign p_term = SW'(p_prod >>> GF);
   end else begin : g_noprop
      assign p_term = '0;
   end

   assign u_raw = {{(SW-AW){integ_nx[AW-1]}}, integ_nx} + p_term;

   bdc_clamp #(.IW(SW), .OW(AW)) u_out_lim (
      .v  (u_raw),
      .lo (U_LO),
      .hi (U_HI),
      .y  (u)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         integ <= '0;
      else if (upd)
         integ <= integ_nx;
   end

endmodule

// File: rtl/bdc_rdiv.sv
module bdc_rdiv #(
   parameter int NW = 36,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic [NW-1:0] quo,
   output logic          fin
);

   localparam int CW = $clog2(NW + 1);

   logic [DW-1:0] rem;
   logic [DW-1:0] den_q;
   logic [DW:0]   trial;
   logic          ge;
   logic [CW-1:0] cnt;

   assign trial = {rem, quo[NW-1]};
   assign ge    = trial >= {1'b0, den_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem   <= '0;
         den_q <= '0;
         quo   <= '0;
         cnt   <= '0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            rem   <= '0;
            den_q <= den;
            quo   <= num;
            cnt   <= CW'(NW);
         end else if (cnt != '0) begin
            rem <= ge ? DW'(trial - {1'b0, den_q}) : DW'(trial);
            quo <= {quo[NW-2:0], ge};
            cnt <= cnt - 1'b1;
            fin <= (cnt == CW'(1));
         end
      end
   end

endmodule

// File: rtl/bridge_duty_ctrl.sv
module bridge_duty_ctrl
   import bdc_pkg::*;
#(
   parameter int W        = 16,
   parameter int AW       = 24,
   parameter int FRAC     = 12,
   parameter int GF       = 8,
   parameter int DUTY_W   = 8,
   parameter int DMAX_PCT = 95,
   parameter bit V_PROP   = 1'b1,
   parameter bit I_PROP   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic signed [W-1:0] v_meas,
   input  logic signed [W-1:0] v_set,
   input  logic signed [W-1:0] v_line,
   input  logic signed [W-1:0] i_dc,
   input  logic [W-1:0]        v_kp,
   input  logic [W-1:0]        v_ki,
   input  logic [W-1:0]        i_kp,
   input  logic [W-1:0]        i_ki,
   input  logic signed [AW-1:0] v_int_lo,
   input  logic signed [AW-1:0] v_int_hi,
   input  logic signed [AW-1:0] i_int_lo,
   input  logic signed [AW-1:0] i_int_hi,
   input  logic [W-1:0]        corr_lim,
   input  logic signed [W-1:0] line_lo,
   input  logic signed [W-1:0] line_hi,
   output logic [DUTY_W-1:0]   duty_a,
   output logic [DUTY_W-1:0]   duty_b,
   output logic                done,
   output logic                trip
);

   localparam int EW   = W + 1;
   localparam int NW   = AW + FRAC;
   localparam int XW   = FRAC + 2;
   localparam int DXW  = AW + 1;
   localparam int ONE  = 1 << FRAC;
   localparam int DMAX = (ONE * DMAX_PCT) / 100;
   localparam int FS   = (1 << DUTY_W) - 1;
   localparam int PRW  = FRAC + DUTY_W + 1;

   if (AW <= W + 1) begin : g_chk_aw
      $error("bridge_duty_ctrl: AW must exceed W+1");
   end
   if (XW >= AW) begin : g_chk_frac
      $error("bridge_duty_ctrl: FRAC too large for AW");
   end
   if (DMAX_PCT < 1 || DMAX_PCT > 100) begin : g_chk_pct
      $error("bridge_duty_ctrl: DMAX_PCT out of range");
   end

   bdc_state_e st;
   logic start;
   logic line_bad;
   logic signed [EW-1:0] err_v;
   logic signed [EW-1:0] err_i;
   logic signed [AW-1:0] u_v;
   logic signed [AW-1:0] u_i;
   logic signed [AW-1:0] c_hi;
   logic signed [AW-1:0] c_lo;
   logic signed [AW-1:0] corr_nx;
   logic [AW-1:0]        u_abs;
   logic [W-1:0]         den;
   logic [NW-1:0]        quo;
   logic                 div_fin;
   logic                 neg_q;
   logic                 bad_q;
   logic signed [AW-1:0] corr_q;
   logic [FRAC:0]        q_mag;
   logic signed [XW-1:0] x_n;
   logic signed [XW:0]   b_sum;
   logic signed [XW:0]   base;
   logic [DUTY_W-1:0]    duty_nx [BDC_PHASES];

   assign start    = smp_vld && (st == ST_IDLE);
   assign line_bad = (v_line <= 0) || (v_line < line_lo) || (v_line > line_hi);
   assign err_v    = {v_set[W-1], v_set} - {v_meas[W-1], v_meas};
   assign err_i    = -{i_dc[W-1], i_dc};

   bdc_pi #(.EW(EW), .GW(W), .AW(AW), .GF(GF), .USE_P(V_PROP)) u_vloop (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (start && !line_bad),
      .err   (err_v),
      .kp    (v_kp),
      .ki    (v_ki),
      .lo    (v_int_lo),
      .hi    (v_int_hi),
      .u     (u_v)
   );

   bdc_pi #(.EW(EW), .GW(W), .AW(AW), .GF(GF), .USE_P(I_PROP)) u_iloop (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (start && !line_bad),
      .err   (err_i),
      .kp    (i_kp),
      .ki    (i_ki),
      .lo    (i_int_lo),
      .hi    (i_int_hi),
      .u     (u_i)
   );

   assign c_hi = {{(AW-W){1'b0}}, corr_lim};
   assign c_lo = -c_hi;

   bdc_clamp #(.IW(AW), .OW(AW)) u_corr_lim (
      .v  (u_i),
      .lo (c_lo),
      .hi (c_hi),
      .y  (corr_nx)
   );

   assign u_abs = u_v[AW-1] ? -u_v : u_v;
   assign den   = line_bad ? W'(1) : v_line;

   bdc_rdiv #(.NW(NW), .DW(W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .num   ({u_abs, {FRAC{1'b0}}}),
      .den   (den),
      .quo   (quo),
      .fin   (div_fin)
   );

   assign q_mag = (quo > NW'(ONE)) ? (FRAC+1)'(ONE) : quo[FRAC:0];
   assign x_n   = neg_q ? -$signed({1'b0, q_mag}) : $signed({1'b0, q_mag});
   assign b_sum = (XW+1)'(x_n) + (XW+1)'(ONE);
   assign base  = b_sum >>> 1;

   for (genvar p = 0; p < BDC_PHASES; p++) begin : g_phase
      logic signed [DXW-1:0] d_raw;
      logic signed [FRAC+1:0] d_c;
      logic [FRAC:0]          d_u;
      logic [PRW-1:0]         prod;

      if (p == 0) begin : g_add
         assign d_raw = DXW'(base) + DXW'(corr_q);
      end else begin : g_sub
         assign d_raw = DXW'(base) - DXW'(corr_q);
      end

      bdc_clamp #(.IW(DXW), .OW(FRAC+2)) u_dlim (
         .v  (d_raw),
         .lo (DXW'(0)),
         .hi (DXW'(DMAX)),
         .y  (d_c)
      );

      assign d_u        = d_c[FRAC:0];
      assign prod       = PRW'(d_u) * PRW'(FS);
      assign duty_nx[p] = DUTY_W'(prod >> FRAC);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         done   <= 1'b0;
         trip   <= 1'b1;
         duty_a <= '0;
         duty_b <= '0;
         neg_q  <= 1'b0;
         bad_q  <= 1'b1;
         corr_q <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_RUN;
                  neg_q  <= u_v[AW-1];
                  bad_q  <= line_bad;
                  corr_q <= corr_nx;
               end
            end
            ST_RUN: begin
               if (div_fin) begin
                  st     <= ST_IDLE;
                  done   <= 1'b1;
                  trip   <= bad_q;
                  duty_a <= bad_q ? '0 : duty_nx[0];
                  duty_b <= bad_q ? '0 : duty_nx[1];
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
   parameter int DUTY_W   = 8,
   parameter int FRAC     = 12,
   parameter int DMAX_PCT = 95
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              trip,
   input logic [DUTY_W-1:0] duty_a,
   input logic [DUTY_W-1:0] duty_b
);

   localparam int DCAP = ((((1 << FRAC) * DMAX_PCT) / 100) * ((1 << DUTY_W) - 1)) >> FRAC;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2

   AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(duty_a) && $stable(duty_b))); // R2

   AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(trip)); // R9

   AST_TRIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      trip |-> (duty_a == '0 && duty_b == '0)); // R8

   AST_DEAD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(duty_a) <= DCAP) && (int'(duty_b) <= DCAP)); // R7

endmodule

bind bridge_duty_ctrl bdc_checker #(
   .DUTY_W   (DUTY_W),
   .FRAC     (FRAC),
   .DMAX_PCT (DMAX_PCT)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .done   (done),
   .trip   (trip),
   .duty_a (duty_a),
   .duty_b (duty_b)
);

// File: tb/bridge_duty_ctrl_tb.sv
module bridge_duty_ctrl_tb;

   localparam int  LAT  = 37;
   localparam longint UMAX = (64'sd1 <<< 23) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld = 1'b0;
   logic signed [15:0] v_meas, v_set, v_line, i_dc, line_lo, line_hi;
   logic [15:0] v_kp, v_ki, i_kp, i_ki, corr_lim;
   logic signed [23:0] v_int_lo, v_int_hi, i_int_lo, i_int_hi;
   logic [7:0] duty_a, duty_b;
   logic done, trip;

   int n_chk = 0;
   int n_bad = 0;
   longint mi_v = 0;
   longint mi_i = 0;
   int exp_a, exp_b;
   bit exp_trip;

   always #10 clk = ~clk;

   bridge_duty_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
      .v_meas(v_meas), .v_set(v_set), .v_line(v_line), .i_dc(i_dc),
      .v_kp(v_kp), .v_ki(v_ki), .i_kp(i_kp), .i_ki(i_ki),
      .v_int_lo(v_int_lo), .v_int_hi(v_int_hi),
      .i_int_lo(i_int_lo), .i_int_hi(i_int_hi),
      .corr_lim(corr_lim), .line_lo(line_lo), .line_hi(line_hi),
      .duty_a(duty_a), .duty_b(duty_b), .done(done), .trip(trip)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic longint sat(input longint v, input longint lo, input longint hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   task automatic model();
      bit bad;
      longint ev, ei, nv, ni, uv, ui, corr, mag, q, x, base, da, db;
      bad = (v_line <= 0) || (v_line < line_lo) || (v_line > line_hi);
      ev = longint'(v_set) - longint'(v_meas);
      nv = sat(mi_v + ((ev * longint'(v_ki)) >>> 8), longint'(v_int_lo), longint'(v_int_hi));
      uv = sat(nv + ((ev * longint'(v_kp)) >>> 8), -UMAX, UMAX);
      ei = -longint'(i_dc);
      ni = sat(mi_i + ((ei * longint'(i_ki)) >>> 8), longint'(i_int_lo), longint'(i_int_hi));
      ui = sat(ni + ((ei * longint'(i_kp)) >>> 8), -UMAX, UMAX);
      corr = sat(ui, -longint'(corr_lim), longint'(corr_lim));
      if (bad) begin
         exp_a = 0; exp_b = 0; exp_trip = 1'b1;
      end else begin
         mi_v = nv; mi_i = ni;
         mag  = (uv < 0) ? -uv : uv;
         q    = (mag * 4096) / longint'(v_line);
         if (q > 4096) q = 4096;
         x    = (uv < 0) ? -q : q;
         base = (x + 4096) >>> 1;
         da   = sat(base + corr, 0, 3891);
         db   = sat(base - corr, 0, 3891);
         exp_a = int'((da * 255) >>> 12);
         exp_b = int'((db * 255) >>> 12);
         exp_trip = 1'b0;
      end
   endtask

   task automatic run_sample(input string tag, input bit poke);
      bit early;
      int pa, pb;
      model();
      pa = duty_a; pb = duty_b;
      early = 1'b0;
      @(negedge clk); smp_vld = 1'b1;
      @(posedge clk);
      @(negedge clk); smp_vld = 1'b0;
      if (done) early = 1'b1;
      for (int i = 1; i <= LAT; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (poke && i == 3) begin
            smp_vld = 1'b1;
            v_meas  = 16'(int'($urandom_range(6000, 0)));
            v_line  = 16'(int'($urandom_range(9000, 100)));
         end
         if (poke && i == 4) smp_vld = 1'b0;
         if (i < LAT && done) early = 1'b1;
         if (i == LAT - 1)
            check(duty_a == 8'(pa) && duty_b == 8'(pb), "R2 hold before done", duty_a, pa);
      end
      check(done == 1'b1, "R2 done at latency", done, 1);
      check(!early, "R2 no early done", early, 0);
      check(duty_a == 8'(exp_a), {tag, " duty_a"}, duty_a, exp_a);
      check(duty_b == 8'(exp_b), {tag, " duty_b"}, duty_b, exp_b);
      check(trip == exp_trip, {tag, " trip"}, trip, exp_trip);
      if (poke) begin
         bit extra;
         extra = 1'b0;
         for (int k = 0; k < 40; k++) begin
            @(posedge clk); @(negedge clk);
            if (done || duty_a != 8'(exp_a) || duty_b != 8'(exp_b)) extra = 1'b1;
         end
         check(!extra, "R3 busy strobe ignored", extra, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20417));
      v_set = 16'sd2000; v_meas = 16'sd1900; v_line = 16'sd4000; i_dc = 16'sd0;
      v_kp = 16'd16; v_ki = 16'd100; i_kp = 16'd32; i_ki = 16'd16;
      v_int_lo = -24'sd1000000; v_int_hi = 24'sd1000000;
      i_int_lo = -24'sd100000;  i_int_hi = 24'sd100000;
      corr_lim = 16'd200; line_lo = 16'sd500; line_hi = 16'sd8000;

      repeat (5) @(negedge clk);
      check(duty_a == 0 && duty_b == 0, "R1 duties in reset", duty_a, 0);
      check(done == 0 && trip == 1, "R1 flags in reset", {done, trip}, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(done == 0 && trip == 1 && duty_a == 0, "R1 after release", trip, 1);

      // R4 nominal and accumulating integrator
      run_sample("R4 nominal", 1'b0);
      run_sample("R4 accumulate", 1'b0);
      run_sample("R4 accumulate", 1'b0);

      // R4 integrator clamp at upper bound
      v_int_hi = 24'sd3000; v_ki = 16'd500; v_meas = 16'sd0;
      run_sample("R4 clamp", 1'b0);
      run_sample("R4 clamp", 1'b0);

      // R7 base clipped high, zero correction
      v_int_hi = 24'sd1000000; v_set = 16'sd30000; v_kp = 16'd200;
      i_kp = 16'd0; i_ki = 16'd0; corr_lim = 16'd0;
      run_sample("R7 cap", 1'b0);

      // R5 base clipped low
      v_set = -16'sd30000;
      run_sample("R5 floor", 1'b0);
      run_sample("R5 floor", 1'b0);

      // R6 correction bounded, split across phases
      v_set = 16'sd2000; v_meas = 16'sd2000; v_kp = 16'd0; v_ki = 16'd0;
      i_dc = 16'sd1500; i_kp = 16'd255; i_ki = 16'd64; corr_lim = 16'd300;
      run_sample("R6 split", 1'b0);
      i_dc = -16'sd1500;
      run_sample("R6 split neg", 1'b0);

      // R8 line faults, R9 recovery with frozen integrators
      v_ki = 16'd100; v_meas = 16'sd1500;
      v_line = 16'sd0;
      run_sample("R8 zero line", 1'b0);
      v_line = 16'sd9000;
      run_sample("R8 over line", 1'b0);
      v_line = 16'sd499;
      run_sample("R8 under line", 1'b0);
      v_line = 16'sd500;
      run_sample("R9 boundary clears", 1'b0);
      v_line = 16'sd8000;
      run_sample("R9 upper boundary", 1'b0);

      // R3 strobe during computation
      v_line = 16'sd4000;
      run_sample("R3 busy", 1'b1);

      for (int n = 0; n < 50; n++) begin
         v_set  = 16'(int'($urandom_range(3000, 0)));
         v_meas = 16'(int'(v_set) + int'($urandom_range(1000, 0)) - 500);
         v_line = 16'(int'($urandom_range(9000, 300)));
         i_dc   = 16'(int'($urandom_range(4000, 0)) - 2000);
         v_kp   = 16'($urandom_range(31, 0));
         v_ki   = 16'($urandom_range(500, 50));
         i_kp   = 16'($urandom_range(255, 0));
         i_ki   = 16'($urandom_range(255, 0));
         v_int_hi = 24'(int'($urandom_range(2000000, 1000)));
         v_int_lo = -v_int_hi;
         i_int_hi = 24'(int'($urandom_range(200000, 100)));
         i_int_lo = -i_int_hi;
         corr_lim = 16'($urandom_range(400, 0));
         run_sample("R7 random", (n % 10) == 5);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule